// File: doc/BRIEF.md
# Endian-Aware Bus Width Adapter

This block connects a processor-side request port to an external memory bus with 32 data bits and four active-low byte-lane strobes. A request is a byte, halfword or word read or write at a byte address. The block places each byte on the lane that the device expects. The lane depends on the byte order and on the width of the attached device. The byte order is captured from a strap pin while reset is asserted and is held fixed after that.

When a request is wider than the device, the block breaks it into several bus cycles at ascending addresses. For reads, it gathers the returned bytes into one result. The kind of device is a configuration input, and each kind accepts only some widths. If the configuration is illegal, or the address is misaligned, the request is flagged as an error and no bus cycle is started. Each bus cycle uses a request/acknowledge handshake. The processor side sees a single one-cycle completion pulse.

Top module: `bus_width_adapter`

## Requirements
- R1: While `rst` is high, `endian_strap` is captured: 0 selects big-endian byte order (byte address 0 is the most significant byte) and 1 selects little-endian (byte address 0 is the least significant byte). Changes on the strap after reset has been released have no effect.
- R2: Encodings: `req_size` and `cfg_dev_width` use 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = reserved. `mem_lane_n[i]` and `mem_wdata[8i+7:8i]` form lane i, where lane 3 is bits 31..24. On a 32-bit device, a byte access at address offset n selects only lane 3-n when big-endian, and only lane n when little-endian.
- R3: On a 32-bit device, a halfword access at offset 0 uses lanes 3 and 2 when big-endian, with bits 15..8 on lane 3. At offset 2 it uses lanes 1 and 0, with bits 15..8 on lane 1. When little-endian, offset 0 uses lanes 1 and 0, offset 2 uses lanes 3 and 2, and bits 7..0 are on the lower lane of the pair.
- R4: On a 32-bit device, a word access selects all four lanes, with bits 31..24 on lane 3 and bits 7..0 on lane 0, in either byte order.
- R5: An access wider than the device is split into (access bytes / device bytes) bus cycles. Their `mem_addr` values start at the request address and increase by the device width. Read bytes from all of the cycles are combined into `req_rdata`. Result bits above the access size read as zero.
- R6: In a split access, the first (lowest-address) cycle carries the most significant part of the data when big-endian and the least significant part when little-endian.
- R7: A 16-bit device uses only lanes 1..0, and an 8-bit device uses only lane 0. Lanes outside the device are never selected, and read data on them is ignored. On a 16-bit device, the even address maps to lane 1 when big-endian and to lane 0 when little-endian.
- R8: `cfg_dev_type` uses 0 = plain memory (8/16/32), 1 = DRAM-class (16/32), 2 = synchronous DRAM (32 only), 3 = card slot (8/16). A width outside the set for the type gives `req_done` with `req_err`=1 and no bus cycle.
- R9: A halfword at an odd address, a word at an address that is not a multiple of 4, or a reserved size gives `req_done` with `req_err`=1 and no bus cycle.
- R10: `mem_req` stays high with stable address, lanes and write data until `mem_ack` is sampled, and is low on the next cycle. `req_done` is a one-cycle pulse, with `req_rdata` and `req_err` valid in that same cycle.
- R11: Reads select the same lanes as writes, with `mem_write` low and `mem_wdata` zero. Writes drive `mem_write` high and put zero on unselected lanes.
- R12: After reset, `mem_req` and `req_done` are 0, and `mem_lane_n` is 4'hF whenever `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the byte order is captured while it is high |
| endian_strap | input | 1 | Byte-order strap: 0 big-endian, 1 little-endian |
| cfg_dev_type | input | 2 | Kind of attached device |
| cfg_dev_width | input | 2 | Width of attached device |
| req_start | input | 1 | One-cycle request pulse, accepted when idle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Access size |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write value, right-aligned |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request rejected; valid with req_done |
| req_rdata | output | 32 | Read value, right-aligned; valid with req_done |
| mem_req | output | 1 | Bus cycle request |
| mem_write | output | 1 | Bus cycle direction |
| mem_addr | output | ADDR_W | Byte address of this bus cycle |
| mem_lane_n | output | 4 | Active-low lane strobes |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_ack | input | 1 | Bus cycle completes |
| mem_rdata | input | 32 | Lane read data, sampled with mem_ack |

## Verification
The hardest case to reach is a split access in which the byte order, the device width and the sub-cycle position all have to agree. A 16-bit or 8-bit device must receive each part of a word in the correct order, and the read parts must land in the correct places in the result. This interaction only appears after a second reset with the opposite strap value.

The stimulus therefore runs the whole access set under both byte orders. It writes through a narrow device and reads the same bytes back through a wide one, so any swap between sub-cycles shows up as a wrong value. The device model answers after varying delays and returns filler bytes on the lanes outside the device.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int BUS_W  = LANES * LANE_W;
  localparam int SEL_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    DEV_PLAIN = 2'd0,
    DEV_DRAM  = 2'd1,
    DEV_SYNC  = 2'd2,
    DEV_CARD  = 2'd3
  } dev_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } bwa_state_e;

  typedef struct packed {
    logic [LANES-1:0]            en;
    logic [LANES-1:0][SEL_W-1:0] sel;
  } lane_map_t;
endpackage

// File: rtl/bwa_req_check.sv
module bwa_req_check
  import bwa_pkg::*;
(
  input  logic [1:0] dev_type,
  input  logic [1:0] dev_width,
  input  logic [1:0] size_log,
  input  logic [1:0] addr_lo,
  output logic       err,
  output logic [1:0] chunk_log,
  output logic [1:0] n_sub_m1
);
  logic width_ok;
  logic align_ok;

  always_comb begin
    unique case (dev_kind_e'(dev_type))
      DEV_PLAIN: width_ok = (dev_width != 2'd3);
      DEV_DRAM:  width_ok = (dev_width == 2'd1) || (dev_width == 2'd2);
      DEV_SYNC:  width_ok = (dev_width == 2'd2);
      default:   width_ok = (dev_width == 2'd0) || (dev_width == 2'd1);
    endcase
  end

  always_comb begin
    unique case (size_log)
      2'd0:    align_ok = 1'b1;
      2'd1:    align_ok = ~addr_lo[0];
      2'd2:    align_ok = (addr_lo == 2'd0);
      default: align_ok = 1'b0;
    endcase
  end

  assign err = ~(width_ok & align_ok);

  always_comb begin
    if (size_log > dev_width) begin
      chunk_log = dev_width;
      n_sub_m1  = (size_log - dev_width == 2'd1) ? 2'd1 : 2'd3;
    end else begin
      chunk_log = size_log;
      n_sub_m1  = 2'd0;
    end
  end
endmodule

// File: rtl/bwa_lane_map.sv
module bwa_lane_map
  import bwa_pkg::*;
(
  input  logic       little,
  input  logic [1:0] size_log,
  input  logic [1:0] width_log,
  input  logic [1:0] chunk_log,
  input  logic [1:0] sub_lo,
  output lane_map_t  map
);
  logic [2:0] dev_b, chunk_b, acc_b;
  logic [2:0] lane3, off3, abs3, pos3, sub3;

  always_comb begin
    dev_b   = 3'd1 << width_log;
    chunk_b = 3'd1 << chunk_log;
    acc_b   = 3'd1 << size_log;
    sub3    = {1'b0, sub_lo};
    map     = '0;
    lane3   = '0;
    off3    = '0;
    abs3    = '0;
    pos3    = '0;
    for (int l = 0; l < LANES; l++) begin
      lane3 = 3'(l);
      off3  = little ? lane3 : (dev_b - 3'd1 - lane3);
      abs3  = (sub3 & ~(dev_b - 3'd1)) + off3;
      pos3  = abs3 & (acc_b - 3'd1);
      if ((lane3 < dev_b) && ((abs3 & ~(chunk_b - 3'd1)) == sub3)) begin
        map.en[l]  = 1'b1;
        map.sel[l] = little ? pos3[1:0] : 2'(acc_b - 3'd1 - pos3);
      end
    end
  end
endmodule

// File: rtl/bwa_rd_assemble.sv
module bwa_rd_assemble
  import bwa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             capture,
  input  lane_map_t        map,
  input  logic [BUS_W-1:0] lane_data,
  output logic [BUS_W-1:0] value
);
  logic [LANES-1:0][LANE_W-1:0] acc_q;
  logic [LANES-1:0][LANE_W-1:0] lanes_in;

  assign lanes_in = lane_data;
  assign value    = acc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (capture) begin
      for (int l = 0; l < LANES; l++) begin
        if (map.en[l]) acc_q[map.sel[l]] <= lanes_in[l];
      end
    end
  end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              endian_strap,
  input  logic [1:0]        cfg_dev_type,
  input  logic [1:0]        cfg_dev_width,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_done,
  output logic              req_err,
  output logic [31:0]       req_rdata,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_lane_n,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  bwa_state_e                   st;
  logic                         le_q;
  logic                         rq_write;
  logic [1:0]                   rq_size;
  logic [LANES-1:0][LANE_W-1:0] rq_wdata;
  logic [ADDR_W-1:0]            sub_addr;
  logic [1:0]                   sub_left;
  logic [1:0]                   chunk_q;
  logic                         err_q;
  lane_map_t                    map_q;

  logic       chk_err;
  logic [1:0] chk_chunk;
  logic [1:0] chk_nm1;
  lane_map_t  map_now;
  logic [BUS_W-1:0] steered;
  logic [BUS_W-1:0] assembled;
  logic             asm_clear;
  logic             asm_capture;

  bwa_req_check u_check (
    .dev_type  (cfg_dev_type),
    .dev_width (cfg_dev_width),
    .size_log  (req_size),
    .addr_lo   (req_addr[1:0]),
    .err       (chk_err),
    .chunk_log (chk_chunk),
    .n_sub_m1  (chk_nm1)
  );

  bwa_lane_map u_map (
    .little    (le_q),
    .size_log  (rq_size),
    .width_log (cfg_dev_width),
    .chunk_log (chunk_q),
    .sub_lo    (sub_addr[1:0]),
    .map       (map_now)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      steered[l*LANE_W +: LANE_W] = (map_now.en[l] && rq_write) ?
                                    rq_wdata[map_now.sel[l]] : '0;
    end
  end

  assign asm_clear   = (st == ST_IDLE) && req_start;
  assign asm_capture = (st == ST_WAIT) && mem_ack && !rq_write;

  bwa_rd_assemble u_asm (
    .clk       (clk),
    .rst       (rst),
    .clear     (asm_clear),
    .capture   (asm_capture),
    .map       (map_q),
    .lane_data (mem_rdata),
    .value     (assembled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      le_q       <= endian_strap;
      rq_write   <= 1'b0;
      rq_size    <= '0;
      rq_wdata   <= '0;
      sub_addr   <= '0;
      sub_left   <= '0;
      chunk_q    <= '0;
      err_q      <= 1'b0;
      map_q      <= '0;
      req_done   <= 1'b0;
      req_err    <= 1'b0;
      req_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_write  <= 1'b0;
      mem_addr   <= '0;
      mem_lane_n <= '1;
      mem_wdata  <= '0;
    end else begin
      req_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_start) begin
            rq_write <= req_write;
            rq_size  <= req_size;
            rq_wdata <= req_wdata;
            sub_addr <= req_addr;
            sub_left <= chk_nm1;
            chunk_q  <= chk_chunk;
            err_q    <= chk_err;
            st       <= chk_err ? ST_DONE : ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          mem_req    <= 1'b1;
          mem_write  <= rq_write;
          mem_addr   <= sub_addr;
          mem_lane_n <= ~map_now.en;
          mem_wdata  <= steered;
          map_q      <= map_now;
          st         <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            mem_write  <= 1'b0;
            mem_lane_n <= '1;
            mem_wdata  <= '0;
            if (sub_left == 2'd0) begin
              st <= ST_DONE;
            end else begin
              sub_addr <= sub_addr + (ADDR_W'(1) << chunk_q);
              sub_left <= sub_left - 2'd1;
              st       <= ST_LAUNCH;
            end
          end
        end
        default: begin
          req_done  <= 1'b1;
          req_err   <= err_q;
          req_rdata <= assembled;
          st        <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              le_q,
  input logic [1:0]        cfg_dev_width,
  input logic              req_done,
  input logic              req_err,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_lane_n,
  input logic [31:0]       mem_wdata
);
  // R1: byte order never changes outside reset
  p_order_fixed_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(le_q));

  // R10: cycle held until acknowledged
  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_lane_n) && $stable(mem_wdata)));

  // R10: released right after acknowledge
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

  // R10: completion is a single pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  // R7: narrow devices keep to the low lanes
  p_half_lanes_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && cfg_dev_width == 2'd1) |-> (mem_lane_n[3:2] == 2'b11));
  p_byte_lanes_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && cfg_dev_width == 2'd0) |-> (mem_lane_n[3:1] == 3'b111));

  // R8 / R9: a rejected request leaves the bus quiet
  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (req_done && req_err) |-> (!mem_req && $past(!mem_req)));

  // R12: no lane selected while idle; some lane selected while active (R11)
  p_idle_lanes_r12: assert property (@(posedge clk) disable iff (rst)
    !mem_req |-> (mem_lane_n == 4'hF));
  p_active_lanes_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_lane_n != 4'hF));
endmodule

bind bus_width_adapter bwa_checker #(.ADDR_W(ADDR_W)) u_bwa_checker (
  .clk           (clk),
  .rst           (rst),
  .le_q          (le_q),
  .cfg_dev_width (cfg_dev_width),
  .req_done      (req_done),
  .req_err       (req_err),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_addr      (mem_addr),
  .mem_lane_n    (mem_lane_n),
  .mem_wdata     (mem_wdata)
);

// File: tb/tb_bus_width_adapter.sv
module tb_bus_width_adapter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        endian_strap = 1'b0;
  logic [1:0]  cfg_dev_type = 2'd0;
  logic [1:0]  cfg_dev_width = 2'd2;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_done, req_err;
  logic [31:0] req_rdata;
  logic        mem_req, mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_lane_n;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  bus_width_adapter #(.ADDR_W(32)) dut (.*);

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  lane_n;
    logic [31:0] wdata;
    logic        wr;
    string       tag;
  } bus_t;
  typedef struct {
    logic [31:0] rdata;
    logic        err;
    string       tag;
  } res_t;

  bus_t bus_q[$];
  res_t res_q[$];
  int vectors = 0;
  int misses = 0;
  bit finished = 0;
  bit cur_le = 0;
  logic [7:0] mem [0:255];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit legal(logic [1:0] t, logic [1:0] w, logic [1:0] sz, logic [31:0] a);
    bit wok, aok;
    case (t)
      2'd0: wok = (w <= 2);
      2'd1: wok = (w == 1) || (w == 2);
      2'd2: wok = (w == 2);
      default: wok = (w <= 1);
    endcase
    case (sz)
      2'd0: aok = 1;
      2'd1: aok = (a[0] == 1'b0);
      2'd2: aok = (a[1:0] == 2'b00);
      default: aok = 0;
    endcase
    return wok && aok;
  endfunction

  // device model: checks each bus cycle against the scoreboard, then answers
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (mem_req === 1'b1) begin
        bus_t e;
        int dv, base;
        if (bus_q.size() == 0) begin
          chk("R8", "unexpected bus cycle", 32'd1, 32'd0);
        end else begin
          e = bus_q.pop_front();
          chk(e.tag, "mem_addr", mem_addr, e.addr);
          chk(e.tag, "mem_lane_n", {28'd0, mem_lane_n}, {28'd0, e.lane_n});
          chk(e.tag, "mem_wdata", mem_wdata, e.wdata);
          chk(e.tag, "mem_write", {31'd0, mem_write}, {31'd0, e.wr});
        end
        repeat (dly) @(negedge clk);
        dly = (dly + 1) % 3;
        dv = 1 << cfg_dev_width;
        base = int'(mem_addr[7:0]) & ~(dv - 1);
        mem_rdata = 32'hEEEE_EEEE;
        for (int l = 0; l < dv; l++) begin
          int ba;
          ba = (base + (cur_le ? l : dv - 1 - l)) & 255;
          mem_rdata[l*8 +: 8] = mem[ba];
          if (mem_write && !mem_lane_n[l]) mem[ba] = mem_wdata[l*8 +: 8];
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        mem_rdata = '0;
      end
    end
  end

  // completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (req_done === 1'b1) begin
        res_t r;
        if (res_q.size() == 0) begin
          chk("R10", "unexpected completion", 32'd1, 32'd0);
        end else begin
          r = res_q.pop_front();
          chk(r.tag, "req_rdata", req_rdata, r.rdata);
          chk(r.tag, "req_err", {31'd0, req_err}, {31'd0, r.err});
          chk(r.tag, "sub-cycles left", bus_q.size(), 0);
        end
      end
    end
  end

  task automatic access(string tag, bit wr, logic [1:0] sz, logic [31:0] a, logic [31:0] wd);
    int acc, dv, c, n;
    bit err;
    logic [31:0] exp_rd;
    res_t r;
    exp_rd = '0;
    err = !legal(cfg_dev_type, cfg_dev_width, sz, a);
    acc = 1 << sz;
    dv = 1 << cfg_dev_width;
    if (!err) begin
      c = (acc > dv) ? dv : acc;
      n = acc / c;
      for (int k = 0; k < n; k++) begin
        bus_t b;
        b.addr = a + k * c;
        b.lane_n = 4'hF;
        b.wdata = '0;
        b.wr = wr;
        b.tag = tag;
        for (int bb = 0; bb < c; bb++) begin
          int a2, o, j, lane;
          a2 = int'(a) + k * c + bb;
          o = a2 - int'(a);
          j = cur_le ? o : acc - 1 - o;
          lane = cur_le ? (a2 % dv) : (dv - 1 - (a2 % dv));
          b.lane_n[lane] = 1'b0;
          if (wr) b.wdata[lane*8 +: 8] = wd[j*8 +: 8];
        end
        bus_q.push_back(b);
      end
      if (!wr) begin
        for (int j = 0; j < acc; j++)
          exp_rd[j*8 +: 8] = mem[(int'(a) + (cur_le ? j : acc - 1 - j)) & 255];
      end
    end
    r.rdata = exp_rd;
    r.err = err;
    r.tag = tag;
    res_q.push_back(r);
    @(negedge clk);
    req_start = 1'b1;
    req_write = wr;
    req_size = sz;
    req_addr = a;
    req_wdata = wd;
    @(negedge clk);
    req_start = 1'b0;
    while (req_done !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(bit strap);
    rst = 1'b1;
    endian_strap = strap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_le = strap;
    @(negedge clk);
  endtask

  task automatic run_set();
    cfg_dev_type = 2'd0;
    cfg_dev_width = 2'd2;
    for (int i = 0; i < 4; i++) access("R2", 0, 2'd0, 32'(i), '0);
    for (int i = 4; i < 8; i++) access("R2", 1, 2'd0, 32'(i), 32'(8'hA0 + i));
    access("R2", 0, 2'd1, 32'd4, '0);
    access("R3", 0, 2'd1, 32'd0, '0);
    access("R3", 0, 2'd1, 32'd2, '0);
    access("R3", 1, 2'd1, 32'd8, 32'h0000_B1C2);
    access("R3", 1, 2'd1, 32'd10, 32'h0000_D3E4);
    access("R3", 0, 2'd2, 32'd8, '0);
    access("R4", 0, 2'd2, 32'd0, '0);
    access("R4", 1, 2'd2, 32'd12, 32'h1122_3344);
    access("R4", 0, 2'd2, 32'd12, '0);
    access("R11", 0, 2'd0, 32'd13, '0);
    // 16-bit device
    cfg_dev_width = 2'd1;
    access("R6", 0, 2'd2, 32'd0, '0);
    access("R7", 0, 2'd1, 32'd2, '0);
    access("R7", 0, 2'd0, 32'd3, '0);
    access("R5", 1, 2'd2, 32'd16, 32'h5566_7788);
    cfg_dev_width = 2'd2;
    access("R5", 0, 2'd2, 32'd16, '0);
    // 8-bit device
    cfg_dev_width = 2'd0;
    access("R6", 0, 2'd2, 32'd0, '0);
    access("R5", 1, 2'd2, 32'd20, 32'h99AA_BBCC);
    access("R7", 0, 2'd1, 32'd22, '0);
    cfg_dev_width = 2'd2;
    access("R5", 0, 2'd2, 32'd20, '0);
    cfg_dev_width = 2'd1;
    access("R5", 1, 2'd1, 32'd26, 32'h0000_F00D);
    cfg_dev_width = 2'd0;
    access("R5", 0, 2'd1, 32'd26, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    do_reset(1'b0);
    // R12: reset state
    chk("R12", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R12", "mem_lane_n", {28'd0, mem_lane_n}, 32'hF);
    chk("R12", "req_done", {31'd0, req_done}, 32'd0);
    // R1: strap moved after reset must not change byte order
    endian_strap = 1'b1;
    run_set();
    // R8: every type and width combination
    for (int t = 0; t < 4; t++) begin
      for (int w = 0; w < 4; w++) begin
        cfg_dev_type = 2'(t);
        cfg_dev_width = 2'(w);
        access("R8", 0, 2'd0, 32'd1, '0);
      end
    end
    // R9: misaligned and reserved size
    cfg_dev_type = 2'd0;
    cfg_dev_width = 2'd2;
    access("R9", 0, 2'd1, 32'd1, '0);
    access("R9", 1, 2'd2, 32'd2, 32'hDEAD_BEEF);
    access("R9", 0, 2'd3, 32'd0, '0);
    access("R9", 0, 2'd2, 32'd12, '0);
    // R1: little-endian after a second reset, strap then released low
    do_reset(1'b1);
    endian_strap = 1'b0;
    run_set();
    cfg_dev_type = 2'd2;
    cfg_dev_width = 2'd1;
    access("R8", 0, 2'd2, 32'd0, '0);
    cfg_dev_type = 2'd0;
    cfg_dev_width = 2'd2;
    repeat (5) @(negedge clk);
    chk("R10", "pending scoreboard items", bus_q.size() + res_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule